// File: doc/BRIEF.md
# Pulse-Coded Sampling Converter Serial Front End

This block is the digital control side of a low-power sampling converter. One start line sets everything. A rising edge wakes the block from shutdown and begins tracking. The falling edge marks the sampling instant and starts a conversion of fixed length. When the conversion ends, the block goes back to shutdown and holds a 12-bit result. An external serial clock then shifts that result out, most significant bit first, on a data line that has its own enable. The analog front end is not part of this block. A parallel sample port supplies the value that the conversion would have produced, and a count of system clocks stands in for the conversion time.

Two operating modes exist. The primary mode selects the first input in the single-ended variant, or unipolar coding in the differential variant. The alternate mode selects the second input, or bipolar coding. The pulse pattern on the start line picks the mode. A plain rising edge picks the primary mode. A short high, then a short low, then high again picks the alternate mode. A new start before the previous result has been fully read out also forces the alternate mode.

The start and serial clock inputs are asynchronous. Each passes through a two-stage synchronizer followed by an edge-detect register. Every action taken on one of their edges therefore shows at the outputs after the third system clock edge that follows the input change.

Top module: `cvt_serial_front`

## Requirements
- R1: After reset: asleep_o=1, busy_o=0, sdo_oe_o=0, sdo_o=0, mode_o=0.
- R2: A rising start edge seen in shutdown sets asleep_o=0, sdo_oe_o=1 and sdo_o=0. It sets mode_o=0 (primary) when no result is still waiting to be read.
- R3: A start high of at least ACQ_CYC system clocks followed by a fall is a sample. sample_i is captured when that fall is detected, and later changes on sample_i do not alter the result.
- R4: A conversion holds busy_o=1 with the line driven low (sdo_oe_o=1, sdo_o=0) for CONV_CYC clocks. It then sets busy_o=0 and asleep_o=1 and drives the result MSB on sdo_o, with sdo_oe_o=1.
- R5: Each serial clock falling edge moves sdo_o to the next lower result bit. The 12th serial clock rising edge releases the line (sdo_oe_o=0, sdo_o=0).
- R6: A start high shorter than ACQ_CYC clocks, then low for fewer than GAP_CYC clocks, then high again selects mode_o=1 (alternate).
- R7: A rising start edge while a result is only partly read sets mode_o=1, drops the old result and drives the line low.
- R8: In the differential variant (DIFF_INPUTS=1) an alternate-mode result is two's complement, formed by inverting the MSB of sample_i. A primary-mode result is sample_i unchanged. The single-ended variant (DIFF_INPUTS=0) always returns sample_i unchanged.
- R9: Serial clock edges during tracking, during conversion, or in shutdown with no result pending change neither sdo_o nor sdo_oe_o, and no result bits are consumed.
- R10: If the low phase after a short start pulse lasts GAP_CYC clocks with no new rise, the block returns to shutdown with the line released and starts no conversion.
- R11: After a complete readout, a single rising start edge again selects mode_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, time base for all counters |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Asynchronous conversion start and mode pulse line |
| sclk_i | input | 1 | Asynchronous external serial clock |
| sample_i | input | 12 | Stand-in for the analog result, offset-binary code |
| sdo_o | output | 1 | Serial data, zero when not enabled |
| sdo_oe_o | output | 1 | Drive enable of the serial data line |
| asleep_o | output | 1 | High in the shutdown state |
| busy_o | output | 1 | High while a conversion runs |
| mode_o | output | 1 | Selected mode: 0 primary, 1 alternate |

## Verification
A wrong phase in the sequencer shows within three system clocks of the start edge that caused it. It appears as asleep_o or busy_o taking the wrong value, or as the data line enabled or released at the wrong moment. A bad mode decision is visible on mode_o as soon as tracking begins. It shows again one conversion later as an inverted result MSB in the differential variant. A shift register that advances on ignored serial clock edges, or misses a valid one, corrupts every following bit of the readout. A bit counter that is off by one moves the line release by one serial clock period.

// File: rtl/cvt_pkg.sv
package cvt_pkg;

  typedef enum logic [1:0] {
    ST_SLEEP = 2'd0,
    ST_TRACK = 2'd1,
    ST_GAP   = 2'd2,
    ST_CONV  = 2'd3
  } cvt_state_e;

  typedef enum logic {
    MODE_PRI = 1'b0,
    MODE_ALT = 1'b1
  } cvt_mode_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/cvt_edge_sync.sv
module cvt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise_o,
  output logic fall_o
);

  // chain_q[0] is the first synchronizer flop, chain_q[STAGES] the edge-detect flop
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-1:0], din};
  end

  assign rise_o =  chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall_o = ~chain_q[STAGES-1] &  chain_q[STAGES];

endmodule

// File: rtl/cvt_seq.sv
module cvt_seq
  import cvt_pkg::*;
#(
  parameter int W           = 12,
  parameter int ACQ_CYC     = 140,
  parameter int CONV_CYC    = 370,
  parameter int GAP_CYC     = 32,
  parameter bit DIFF_INPUTS = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         st_rise_i,
  input  logic         st_fall_i,
  input  logic         pending_i,
  input  logic [W-1:0] sample_i,
  output logic         wake_o,
  output logic         load_o,
  output logic         release_o,
  output logic [W-1:0] word_o,
  output logic         asleep_o,
  output logic         busy_o,
  output logic         mode_o
);

  localparam int unsigned TMR_MAX = max3(ACQ_CYC, CONV_CYC, GAP_CYC);
  localparam int TW = $clog2(TMR_MAX + 1);
  localparam logic [TW-1:0] ACQ_LAST  = TW'(ACQ_CYC - 1);
  localparam logic [TW-1:0] CONV_LAST = TW'(CONV_CYC - 1);
  localparam logic [TW-1:0] GAP_LAST  = TW'(GAP_CYC - 1);
  localparam logic [TW-1:0] TMR_TOP   = TW'(TMR_MAX);

  cvt_state_e   st_q, st_d;
  cvt_mode_e    mode_q, mode_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [W-1:0]  smp_q;
  logic          capture;

  always_comb begin
    st_d      = st_q;
    mode_d    = mode_q;
    tmr_d     = tmr_q;
    wake_o    = 1'b0;
    load_o    = 1'b0;
    release_o = 1'b0;
    capture   = 1'b0;
    unique case (st_q)
      ST_SLEEP: begin
        if (st_rise_i) begin
          st_d   = ST_TRACK;
          tmr_d  = '0;
          wake_o = 1'b1;
          mode_d = pending_i ? MODE_ALT : MODE_PRI;
        end
      end
      ST_TRACK: begin
        if (st_fall_i) begin
          tmr_d = '0;
          if (tmr_q >= ACQ_LAST) begin
            st_d    = ST_CONV;
            capture = 1'b1;
          end else begin
            st_d = ST_GAP;
          end
        end else if (tmr_q != TMR_TOP) begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      ST_GAP: begin
        if (st_rise_i) begin
          st_d   = ST_TRACK;
          tmr_d  = '0;
          mode_d = MODE_ALT;
        end else if (tmr_q == GAP_LAST) begin
          st_d      = ST_SLEEP;
          release_o = 1'b1;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      ST_CONV: begin
        if (tmr_q == CONV_LAST) begin
          st_d   = ST_SLEEP;
          load_o = 1'b1;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      default: st_d = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_SLEEP;
      mode_q <= MODE_PRI;
      tmr_q  <= '0;
      smp_q  <= '0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      tmr_q  <= tmr_d;
      if (capture) smp_q <= sample_i;
    end
  end

  generate
    if (DIFF_INPUTS) begin : g_diff
      // alternate mode: offset binary to two's complement
      assign word_o = (mode_q == MODE_ALT) ? {~smp_q[W-1], smp_q[W-2:0]} : smp_q;
    end else begin : g_single
      assign word_o = smp_q;
    end
  endgenerate

  assign asleep_o = (st_q == ST_SLEEP);
  assign busy_o   = (st_q == ST_CONV);
  assign mode_o   = mode_q;

  // R6: once tracking, the mode cannot change until the phase is left
  a_r6_mode_hold: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_TRACK && $past(st_q) == ST_TRACK) |-> $stable(mode_q));

endmodule

// File: rtl/cvt_shift.sv
module cvt_shift #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wake_i,
  input  logic         load_i,
  input  logic         release_i,
  input  logic [W-1:0] word_i,
  input  logic         en_i,
  input  logic         sck_rise_i,
  input  logic         sck_fall_i,
  output logic         sdo_o,
  output logic         oe_o,
  output logic         pending_o
);

  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(W - 1);

  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;
  logic          act_q, sdo_q, oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (wake_i) begin
      act_q <= 1'b0;
      oe_q  <= 1'b1;
      sdo_q <= 1'b0;
    end else if (load_i) begin
      sh_q  <= word_i;
      cnt_q <= '0;
      act_q <= 1'b1;
      oe_q  <= 1'b1;
      sdo_q <= word_i[W-1];
    end else if (release_i) begin
      act_q <= 1'b0;
      oe_q  <= 1'b0;
      sdo_q <= 1'b0;
    end else if (act_q && en_i) begin
      if (sck_fall_i) begin
        sh_q  <= {sh_q[W-2:0], 1'b0};
        sdo_q <= sh_q[W-2];
      end else if (sck_rise_i) begin
        if (cnt_q == LAST_BIT) begin
          act_q <= 1'b0;
          oe_q  <= 1'b0;
          sdo_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign sdo_o     = sdo_q;
  assign oe_o      = oe_q;
  assign pending_o = act_q;

  // R5: a released line never carries a one
  a_r5_off_quiet: assert property (@(posedge clk) disable iff (rst)
    !oe_q |-> !sdo_q);

  // R2: the line is always enabled at a low level first
  a_r2_rise_low: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_q) |-> !sdo_q);

endmodule

// File: rtl/cvt_serial_front.sv
module cvt_serial_front #(
  parameter int W           = 12,
  parameter int ACQ_CYC     = 140,
  parameter int CONV_CYC    = 370,
  parameter int GAP_CYC     = 32,
  parameter int SYNC_STAGES = 2,
  parameter bit DIFF_INPUTS = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         sclk_i,
  input  logic [W-1:0] sample_i,
  output logic         sdo_o,
  output logic         sdo_oe_o,
  output logic         asleep_o,
  output logic         busy_o,
  output logic         mode_o
);

  logic st_rise, st_fall, sck_rise, sck_fall;
  logic wake, load, rel, pending;
  logic [W-1:0] word;

  cvt_edge_sync #(.STAGES(SYNC_STAGES)) u_start_sync (
    .clk(clk), .rst(rst), .din(start_i), .rise_o(st_rise), .fall_o(st_fall)
  );

  cvt_edge_sync #(.STAGES(SYNC_STAGES)) u_sclk_sync (
    .clk(clk), .rst(rst), .din(sclk_i), .rise_o(sck_rise), .fall_o(sck_fall)
  );

  cvt_seq #(
    .W(W), .ACQ_CYC(ACQ_CYC), .CONV_CYC(CONV_CYC), .GAP_CYC(GAP_CYC),
    .DIFF_INPUTS(DIFF_INPUTS)
  ) u_seq (
    .clk(clk), .rst(rst),
    .st_rise_i(st_rise), .st_fall_i(st_fall), .pending_i(pending),
    .sample_i(sample_i),
    .wake_o(wake), .load_o(load), .release_o(rel), .word_o(word),
    .asleep_o(asleep_o), .busy_o(busy_o), .mode_o(mode_o)
  );

  cvt_shift #(.W(W)) u_shift (
    .clk(clk), .rst(rst),
    .wake_i(wake), .load_i(load), .release_i(rel), .word_i(word),
    .en_i(asleep_o), .sck_rise_i(sck_rise), .sck_fall_i(sck_fall),
    .sdo_o(sdo_o), .oe_o(sdo_oe_o), .pending_o(pending)
  );

  // R4: while converting the line is held driven low
  a_r4_busy_quiet: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (sdo_oe_o && !sdo_o));

  // R4: a conversion ends in shutdown with the result on an enabled line
  a_r4_end_sleep: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (asleep_o && sdo_oe_o));

endmodule

// File: tb/cvt_serial_front_tb.sv
module cvt_serial_front_tb;

  localparam int W    = 12;
  localparam int ACQ  = 140;
  localparam int CONV = 370;
  localparam int GAP  = 32;

  logic clk = 1'b0;
  logic rst, start, sclk;
  logic [W-1:0] sample;
  logic sdo, oe, asleep, busy, mode;
  logic sdo_s, oe_s, asleep_s, busy_s, mode_s;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  cvt_serial_front #(.DIFF_INPUTS(1'b1)) u_dut (
    .clk(clk), .rst(rst), .start_i(start), .sclk_i(sclk), .sample_i(sample),
    .sdo_o(sdo), .sdo_oe_o(oe), .asleep_o(asleep), .busy_o(busy), .mode_o(mode)
  );

  cvt_serial_front #(.DIFF_INPUTS(1'b0)) u_dut_se (
    .clk(clk), .rst(rst), .start_i(start), .sclk_i(sclk), .sample_i(sample),
    .sdo_o(sdo_s), .sdo_oe_o(oe_s), .asleep_o(asleep_s), .busy_o(busy_s), .mode_o(mode_s)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [W-1:0] twos(input logic [W-1:0] v);
    return {~v[W-1], v[W-2:0]};
  endfunction

  // rising start from shutdown; check the wake-up state
  task automatic begin_single(input logic exp_mode, input string req);
    start = 1'b1;
    clocks(4);
    check({req, " awake"}, {asleep, asleep_s}, 2'b00);
    check({req, " line low"}, {oe, sdo, oe_s, sdo_s}, 4'b1010);
    check({req, " mode"}, {mode, mode_s}, {exp_mode, exp_mode});
    clocks(ACQ + 16);
  endtask

  // falling start, full conversion, sample port disturbed midway
  task automatic finish_conv(input logic [W-1:0] ed, input logic [W-1:0] es);
    start = 1'b0;
    clocks(10);
    sample = sample ^ {W{1'b1}};
    clocks(CONV - 8);
    check("R4 busy before end", {busy, oe, sdo}, 3'b110);
    clocks(1);
    check("R4 done state", {busy, asleep, oe}, 3'b011);
    check("R3 R4 msb diff", sdo, ed[W-1]);
    check("R3 R4 msb single", sdo_s, es[W-1]);
  endtask

  task automatic sclk_period();
    sclk = 1'b1;
    clocks(4);
    sclk = 1'b0;
    clocks(4);
  endtask

  task automatic read_bits(input int n, input logic [W-1:0] ed, input logic [W-1:0] es);
    for (int i = 0; i < n; i++) begin
      check("R5 R8 bit diff", sdo, ed[W-1-i]);
      check("R5 R8 bit single", sdo_s, es[W-1-i]);
      sclk_period();
    end
    if (n == W) check("R5 released", {oe, sdo, oe_s, sdo_s}, 4'b0000);
  endtask

  task automatic t_reset();
    check("R1 asleep", {asleep, asleep_s}, 2'b11);
    check("R1 busy", {busy, busy_s}, 2'b00);
    check("R1 line", {oe, sdo, oe_s, sdo_s}, 4'b0000);
    check("R1 mode", {mode, mode_s}, 2'b00);
  endtask

  task automatic t_single(input logic [W-1:0] v, input string req);
    sample = v;
    begin_single(1'b0, req);
    finish_conv(v, v);
    read_bits(W, v, v);
  endtask

  task automatic t_double(input logic [W-1:0] v);
    sample = v;
    start = 1'b1; clocks(5);
    start = 1'b0; clocks(5);
    start = 1'b1; clocks(4);
    check("R6 mode alt", {mode, mode_s}, 2'b11);
    check("R6 tracking", {asleep, oe, sdo}, 3'b010);
    clocks(ACQ + 16);
    finish_conv(twos(v), v);
    read_bits(W, twos(v), v);
  endtask

  task automatic t_partial(input logic [W-1:0] a, input logic [W-1:0] b);
    sample = a;
    begin_single(1'b0, "R2");
    finish_conv(a, a);
    read_bits(8, a, a);
    sample = b;
    start = 1'b1;
    clocks(4);
    check("R7 mode alt", {mode, mode_s}, 2'b11);
    check("R7 line low", {oe, sdo, oe_s, sdo_s}, 4'b1010);
    clocks(ACQ + 16);
    finish_conv(twos(b), b);
    read_bits(W, twos(b), b);
  endtask

  task automatic t_ignore(input logic [W-1:0] v);
    sample = v;
    start = 1'b1;
    clocks(4);
    for (int k = 0; k < 3; k++) sclk_period();
    check("R9 track line", {oe, sdo, asleep}, 3'b100);
    clocks(ACQ);
    start = 1'b0;
    for (int k = 0; k < 5; k++) sclk_period();
    check("R9 conv line", {busy, oe, sdo}, 3'b110);
    clocks(CONV + 2 - 40);
    check("R9 still busy", busy, 1'b1);
    clocks(1);
    check("R9 msb intact", {asleep, sdo}, {1'b1, v[W-1]});
    read_bits(W, v, v);
    for (int k = 0; k < 2; k++) sclk_period();
    check("R9 idle no data", {oe, sdo, oe_s, sdo_s}, 4'b0000);
  endtask

  task automatic t_abort();
    start = 1'b1; clocks(5);
    start = 1'b0; clocks(GAP + 10);
    check("R10 back asleep", {asleep, busy}, 2'b10);
    check("R10 released", {oe, sdo}, 2'b00);
    clocks(CONV + 40);
    check("R10 no conversion", {asleep, busy, oe}, 3'b100);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; sclk = 1'b0; sample = '0;
    clocks(5);
    rst = 1'b0;
    clocks(2);
    t_reset();
    t_single(12'h9A5, "R2");
    t_double(12'h3C1);
    t_partial(12'hE07, 12'h5F0);
    t_single(12'h07E, "R11");
    t_ignore(12'h801);
    t_abort();
    t_single(12'hFFF, "R11");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule